// File: doc/BRIEF.md
# Two-Frame E1 Receive Slip Buffer

This block sits on the receive side of an E1 framer. It separates the recovered line timing from the local system timing. Serial NRZ data comes in on the line clock, with a one-cycle marker on the first bit of each frame. The bits are written into a store that holds two 256-bit frames, 32 timeslots of 8 bits each. A reader in the system clock domain replays the store. Each replayed frame starts at a frame pulse that the system supplies.

Both clocks run at nominally 2.048 MHz, so the write and read positions drift apart slowly. The reader makes one decision at the start of every output frame. It compares its position with a Gray-coded, two-flop-synchronised copy of the write position. If the reader would catch the writer, it replays the last complete frame. If the writer would lap the reader, one whole frame is dropped. Each slip raises a one-cycle flag, and a direction bit records which kind of slip it was.

When the store is disabled, the data and the frame marker pass through on the line clock with one register of delay. In that mode the system frame pulse is ignored.

Top module: `e1_elastic_store`

## Requirements
- R1: Frame write.
  - Writing is in write-position order, and the store holds two frames of 256 bits.
  - A bit presented with `wr_fsync` high is stored at position 0 of the frame slot not currently being written.
  - With no pulse, the write position wraps to the other slot after position 255.
- R2: Stored-mode replay. With `store_en` high and no slip, each output frame is one complete written frame, and successive output frames are successive written frames. Position 0 (MSB of timeslot 0) is output first.
- R3: Read alignment.
  - In stored mode, `out_sync` is high exactly one `rd_clk` cycle after `rd_fsync` is sampled high, and the read frame restarts at position 0.
  - With no pulse, the read side wraps by itself after position 255.
- R4: Repeat slip.
  - At a read frame start, the phase is the write position minus the start of the frame slot the reader would enter next.
  - If this phase is less than half a frame (128 bits), the frame just read is replayed.
  - `slip_flag`=1 and `slip_dir`=1 are reported on that frame's `out_sync` cycle.
- R5: Delete slip.
  - At a read frame start, if the phase of R4 is 384 bits or more, the older slot is skipped and the slot now being written is read.
  - One written frame never appears at the output.
  - `slip_flag`=1 and `slip_dir`=0 are reported on that frame's `out_sync` cycle.
- R6: Slip flag timing.
  - `slip_flag` is high only in a cycle where `out_sync` is high.
  - It stays low on frames that follow their predecessor without a slip.
  - `slip_dir` keeps its last value between slips.
- R7: Bypass.
  - With `store_en` low, `out_data` and `out_sync` equal `wr_data` and `wr_fsync` one `wr_clk` cycle earlier.
  - `rd_fsync` has no effect, and `slip_flag` stays 0.
- R8: Reset. While reset is high, `out_data`, `out_sync` and `slip_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered line clock |
| wr_rst | input | 1 | Synchronous active-high reset, line domain |
| wr_data | input | 1 | Incoming NRZ serial bit |
| wr_fsync | input | 1 | One-cycle marker on bit 0 of a line frame |
| rd_clk | input | 1 | System clock |
| rd_rst | input | 1 | Synchronous active-high reset, system domain |
| rd_fsync | input | 1 | System frame pulse; used only when the store is enabled |
| store_en | input | 1 | 1 selects the slip buffer, 0 selects pass-through |
| out_data | output | 1 | Replayed NRZ serial bit |
| out_sync | output | 1 | High with bit 0 of each output frame |
| slip_flag | output | 1 | One-cycle pulse on the first bit of a slipped frame |
| slip_dir | output | 1 | 1 = last slip repeated a frame, 0 = it deleted one |

## Verification
A corrupted write or read position shows up at the ports within one frame. A replayed frame then fails to match the pattern of any recently written frame, or consecutive output frames step by something other than 0, 1 or 2. A wrong slip decision appears at the next read frame start, as a repeat or skip without a flag, or a flag without one. A faulty synchroniser gives the same symptom, and a broken frame counter misplaces `out_sync` within one cycle of the missed pulse. In bypass, any error in the line registers differs from the input one cycle later.

// File: rtl/e1es_pkg.sv
package e1es_pkg;

    localparam int unsigned SLOTS      = 32;
    localparam int unsigned SLOT_BITS  = 8;
    localparam int unsigned FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int unsigned FRAMES     = 2;
    localparam int unsigned BIT_W      = $clog2(FRAME_BITS);
    localparam int unsigned ADDR_W     = BIT_W + $clog2(FRAMES);
    localparam int unsigned STORE_BITS = FRAMES * FRAME_BITS;
    localparam int unsigned HALF_FRAME = FRAME_BITS / 2;

    typedef logic [BIT_W-1:0]  bitpos_t;
    typedef logic [ADDR_W-1:0] addr_vec_t;

    typedef struct packed {
        logic    frm;
        bitpos_t pos;
    } es_addr_t;

    typedef enum logic {
        SLIP_DELETE = 1'b0,
        SLIP_REPEAT = 1'b1
    } slip_dir_e;

    localparam bitpos_t  LAST_POS      = bitpos_t'(FRAME_BITS - 1);
    localparam es_addr_t WR_RESET_ADDR = '{frm: 1'b1, pos: LAST_POS};
    localparam es_addr_t RD_RESET_ADDR = '{frm: 1'b0, pos: LAST_POS};

    function automatic addr_vec_t to_gray(addr_vec_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic addr_vec_t from_gray(addr_vec_t g);
        addr_vec_t b;
        b[ADDR_W-1] = g[ADDR_W-1];
        for (int i = ADDR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Position that follows cur; a restart or a wrap opens a frame slot.
    function automatic es_addr_t step_addr(es_addr_t cur, logic restart, logic hold_slot);
        es_addr_t n;
        if (restart || cur.pos == LAST_POS) begin
            n.pos = '0;
            n.frm = hold_slot ? cur.frm : ~cur.frm;
        end else begin
            n.pos = cur.pos + 1'b1;
            n.frm = cur.frm;
        end
        return n;
    endfunction

endpackage

// File: rtl/es_frame_ram.sv
module es_frame_ram
    import e1es_pkg::*;
(
    input  logic     wr_clk,
    input  logic     we,
    input  es_addr_t waddr,
    input  logic     wbit,
    input  es_addr_t raddr,
    output logic     rbit
);
    logic mem [STORE_BITS];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wbit;
        end
    end

    assign rbit = mem[raddr];
endmodule

// File: rtl/es_gray_sync.sv
module es_gray_sync #(
    parameter int unsigned      W      = 9,
    parameter int unsigned      STAGES = 2,
    parameter logic [W-1:0]     INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stage[i] <= INIT;
            end
        end else begin
            stage[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl
    import e1es_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fsync,
    output es_addr_t  cur_addr,
    output es_addr_t  last_q,
    output addr_vec_t gray_q
);
    always_comb begin
        cur_addr = step_addr(last_q, fsync, 1'b0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= WR_RESET_ADDR;
            gray_q <= to_gray(WR_RESET_ADDR);
        end else begin
            last_q <= cur_addr;
            gray_q <= to_gray(cur_addr);
        end
    end
endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl
    import e1es_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fsync,
    input  addr_vec_t wr_gray,
    output es_addr_t  cur_addr,
    output es_addr_t  last_q,
    output logic      frame_start,
    output logic      do_repeat,
    output logic      do_delete
);
    addr_vec_t wr_pos;
    addr_vec_t next_slot_base;
    addr_vec_t phase;

    always_comb begin
        frame_start    = fsync || (last_q.pos == LAST_POS);
        wr_pos         = from_gray(wr_gray);
        next_slot_base = {~last_q.frm, {BIT_W{1'b0}}};
        phase          = wr_pos - next_slot_base;
        do_repeat      = frame_start && (phase < addr_vec_t'(HALF_FRAME));
        do_delete      = frame_start && (phase >= addr_vec_t'(FRAME_BITS + HALF_FRAME));
        cur_addr       = step_addr(last_q, fsync, do_repeat || do_delete);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= RD_RESET_ADDR;
        end else begin
            last_q <= cur_addr;
        end
    end
endmodule

// File: rtl/e1_elastic_store.sv
module e1_elastic_store
    import e1es_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic wr_clk,
    input  logic wr_rst,
    input  logic wr_data,
    input  logic wr_fsync,
    input  logic rd_clk,
    input  logic rd_rst,
    input  logic rd_fsync,
    input  logic store_en,
    output logic out_data,
    output logic out_sync,
    output logic slip_flag,
    output logic slip_dir
);
    // ---------------- line clock domain ----------------
    es_addr_t  wr_addr;
    es_addr_t  wr_last;
    addr_vec_t wr_gray;
    logic      line_bit_q;
    logic      line_sync_q;

    es_wr_ctrl u_wr (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .fsync    (wr_fsync),
        .cur_addr (wr_addr),
        .last_q   (wr_last),
        .gray_q   (wr_gray)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            line_bit_q  <= 1'b0;
            line_sync_q <= 1'b0;
        end else begin
            line_bit_q  <= wr_data;
            line_sync_q <= wr_fsync;
        end
    end

    // ---------------- storage ----------------
    es_addr_t rd_addr;
    logic     ram_bit;

    es_frame_ram u_ram (
        .wr_clk (wr_clk),
        .we     (!wr_rst),
        .waddr  (wr_addr),
        .wbit   (wr_data),
        .raddr  (rd_addr),
        .rbit   (ram_bit)
    );

    // ---------------- system clock domain ----------------
    logic      rd_side_rst;
    logic      rd_pulse;
    addr_vec_t wr_gray_rd;
    es_addr_t  rd_last;
    logic      rd_start;
    logic      rd_repeat;
    logic      rd_delete;
    logic      st_bit_q;
    logic      st_sync_q;
    logic      st_slip_q;
    slip_dir_e st_dir_q;

    assign rd_side_rst = rd_rst || !store_en;
    assign rd_pulse    = rd_fsync && store_en;

    es_gray_sync #(
        .W      (ADDR_W),
        .STAGES (SYNC_STAGES),
        .INIT   (to_gray(WR_RESET_ADDR))
    ) u_sync (
        .clk (rd_clk),
        .rst (rd_side_rst),
        .d   (wr_gray),
        .q   (wr_gray_rd)
    );

    es_rd_ctrl u_rd (
        .clk         (rd_clk),
        .rst         (rd_side_rst),
        .fsync       (rd_pulse),
        .wr_gray     (wr_gray_rd),
        .cur_addr    (rd_addr),
        .last_q      (rd_last),
        .frame_start (rd_start),
        .do_repeat   (rd_repeat),
        .do_delete   (rd_delete)
    );

    always_ff @(posedge rd_clk) begin
        if (rd_side_rst) begin
            st_bit_q  <= 1'b0;
            st_sync_q <= 1'b0;
            st_slip_q <= 1'b0;
            st_dir_q  <= SLIP_DELETE;
        end else begin
            st_bit_q  <= ram_bit;
            st_sync_q <= rd_start;
            st_slip_q <= rd_repeat || rd_delete;
            if (rd_repeat) begin
                st_dir_q <= SLIP_REPEAT;
            end else if (rd_delete) begin
                st_dir_q <= SLIP_DELETE;
            end
        end
    end

    // ---------------- output selection ----------------
    assign out_data  = store_en ? st_bit_q  : line_bit_q;
    assign out_sync  = store_en ? st_sync_q : line_sync_q;
    assign slip_flag = store_en && st_slip_q;
    assign slip_dir  = st_dir_q;
endmodule

// File: rtl/es_checker.sv
module es_checker
    import e1es_pkg::*;
(
    input logic    wr_clk,
    input logic    wr_rst,
    input logic    wr_data,
    input logic    wr_fsync,
    input logic    rd_clk,
    input logic    rd_rst,
    input logic    rd_fsync,
    input logic    store_en,
    input logic    out_data,
    input logic    out_sync,
    input logic    slip_flag,
    input bitpos_t wr_pos,
    input bitpos_t rd_pos
);
    // R1: a line frame marker places the next stored bit at position 0
    assert_wr_restart_R1: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_fsync |=> (wr_pos == '0));

    // R3: a system frame pulse restarts the read frame and marks the output
    assert_rd_restart_R3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_fsync && store_en) |=> (out_sync && rd_pos == '0));

    // R6: a slip is only reported on the first bit of an output frame
    assert_slip_on_frame_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
        slip_flag |-> out_sync);

    // R7: no slip is reported unless the store was enabled
    assert_slip_needs_store_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        slip_flag |-> $past(store_en));

    // R7: pass-through mode forwards the line bit after one register
    assert_bypass_follow_R7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!store_en && $past(!wr_rst)) |-> (out_data == $past(wr_data)));
endmodule

bind e1_elastic_store es_checker u_chk (
    .wr_clk    (wr_clk),
    .wr_rst    (wr_rst),
    .wr_data   (wr_data),
    .wr_fsync  (wr_fsync),
    .rd_clk    (rd_clk),
    .rd_rst    (rd_rst),
    .rd_fsync  (rd_fsync),
    .store_en  (store_en),
    .out_data  (out_data),
    .out_sync  (out_sync),
    .slip_flag (slip_flag),
    .wr_pos    (wr_last.pos),
    .rd_pos    (rd_last.pos)
);

// File: tb/sim_e1_elastic_store.sv
module sim_e1_elastic_store;
    localparam int FRAME = 256;
    localparam int MATCH = 192;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, store_en, wr_data, wr_fsync, rd_fsync;
    logic out_data, out_sync, slip_flag, slip_dir;

    e1_elastic_store u0 (
        .wr_clk    (clk),
        .wr_rst    (rst),
        .wr_data   (wr_data),
        .wr_fsync  (wr_fsync),
        .rd_clk    (clk),
        .rd_rst    (rst),
        .rd_fsync  (rd_fsync),
        .store_en  (store_en),
        .out_data  (out_data),
        .out_sync  (out_sync),
        .slip_flag (slip_flag),
        .slip_dir  (slip_dir)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int wk = 0;
    int wcnt, rcnt, wr_period, rd_period, scen;
    logic prev_wd, prev_ws, prev_rfs;
    logic fr_bits [FRAME];
    int fr_len, fr_seen, prevk, n_rep, n_del, n_norm;
    logic fr_slip, fr_dir;
    bit collecting, aligned;

    function automatic logic pat(int k, int b);
        logic [31:0] x;
        x = (32'(k) * 32'd256 + 32'(b)) * 32'h9E3779B1;
        return x[19] ^ x[27];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_frame();
        int id;
        int d;
        bit hit;
        id = -1;
        if (fr_len >= MATCH) begin
            for (int kk = wk; kk >= 0 && kk >= wk - 8; kk--) begin
                hit = 1;
                for (int b = 0; b < MATCH; b++) begin
                    if (fr_bits[b] !== pat(kk, b)) hit = 0;
                end
                if (hit && id < 0) id = kk;
            end
        end
        fr_seen++;
        if (fr_seen > 3) begin
            // R1 (short line frames) and R2: every replayed frame is a written frame
            if (scen == 2) check(id >= 0, "R1", "replayed frame matches a written frame", id, wk);
            else           check(id >= 0, "R2", "replayed frame matches a written frame", id, wk);
            if (id >= 0 && prevk >= 0) begin
                d = id - prevk;
                if (d == 1) begin
                    n_norm++;
                    check(!fr_slip, "R6", "no flag on an unslipped frame", fr_slip, 0);
                end else if (d == 0) begin
                    n_rep++;
                    check(fr_slip && fr_dir == 1'b1, "R4", "repeat flagged with dir 1",
                          {fr_slip, fr_dir}, 3);
                end else if (d == 2) begin
                    n_del++;
                    check(fr_slip && fr_dir == 1'b0, "R5", "delete flagged with dir 0",
                          {fr_slip, fr_dir}, 2);
                end else begin
                    check(0, "R2", "frame sequence step", d, 1);
                end
            end
        end
        prevk = id;
    endtask

    task automatic step(input bit in_reset);
        @(negedge clk);
        if (rst) begin
            // R8: outputs cleared while reset is high
            check(out_data == 1'b0 && out_sync == 1'b0 && slip_flag == 1'b0, "R8",
                  "reset outputs", {out_data, out_sync, slip_flag}, 0);
        end else if (store_en) begin
            if (out_sync) begin
                if (collecting) finish_frame();
                collecting = 1;
                fr_len  = 0;
                fr_slip = slip_flag;
                fr_dir  = slip_dir;
            end
            if (collecting && fr_len < FRAME) begin
                fr_bits[fr_len] = out_data;
                fr_len++;
            end
            if (prev_rfs) aligned = 1;
            if (aligned) check(out_sync == prev_rfs, "R3", "out_sync one cycle after rd_fsync",
                               out_sync, prev_rfs);
            check(!slip_flag || out_sync, "R6", "slip flag outside frame start", slip_flag, 0);
        end else begin
            check(out_data == prev_wd, "R7", "bypass data", out_data, prev_wd);
            check(out_sync == prev_ws, "R7", "bypass sync", out_sync, prev_ws);
            check(slip_flag == 1'b0, "R7", "no slip in bypass", slip_flag, 0);
        end
        rst = in_reset;
        if (in_reset) begin
            wr_fsync = 0;
            wr_data  = 0;
            rd_fsync = 0;
        end else begin
            wr_fsync = (wcnt == 0);
            wr_data  = pat(wk, wcnt);
            rd_fsync = (rcnt == 0);
            wcnt++;
            if (wcnt == wr_period) begin
                wcnt = 0;
                wk++;
            end
            rcnt++;
            if (rcnt == rd_period) rcnt = 0;
        end
        prev_wd  = wr_data;
        prev_ws  = wr_fsync;
        prev_rfs = rd_fsync;
    endtask

    task automatic run(input int s, input logic en, input int wp, input int rp,
                       input int roff, input int ncyc);
        scen = s;
        wr_period = wp;
        rd_period = rp;
        store_en  = en;
        wcnt = 0;
        rcnt = rp - roff;
        fr_len = 0; fr_seen = 0; prevk = -1;
        n_rep = 0; n_del = 0; n_norm = 0;
        collecting = 0; aligned = 0;
        for (int i = 0; i < 4; i++) step(1);
        for (int i = 0; i < ncyc; i++) step(0);
    endtask

    initial begin
        rst = 1; store_en = 0; wr_data = 0; wr_fsync = 0; rd_fsync = 0;
        prev_wd = 0; prev_ws = 0; prev_rfs = 0;

        // Equal frame rates: R2 steady replay, no slips
        run(0, 1'b1, FRAME, FRAME, 160, 4000);
        check(n_norm > 8 && n_rep == 0 && n_del == 0, "R2", "steady replay without slips",
              n_norm * 100 + n_rep + n_del, 1200);

        // System frames of 200 bits: reader gains, R4 repeats
        run(1, 1'b1, FRAME, 200, 160, 5000);
        check(n_rep > 0, "R4", "repeat slips occurred", n_rep, 1);
        check(n_del == 0, "R5", "no delete while reader runs ahead", n_del, 0);

        // Line frames of 200 bits: writer gains, R5 deletes, R1 restart
        run(2, 1'b1, 200, FRAME, 160, 5000);
        check(n_del > 0, "R5", "delete slips occurred", n_del, 1);
        check(n_rep == 0, "R4", "no repeat while writer runs ahead", n_rep, 0);

        // Pass-through with system pulses toggling: R7
        run(3, 1'b0, FRAME, 60, 10, 800);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule